// File: doc/BRIEF.md
# Complementary PWM Timer with Dead Band and Kill

This block is a 16-bit timer/counter that drives a pair of complementary PWM outputs for half-bridge style loads. A counter runs against a period value and a compare value. It can count edge-aligned (up, then wrap) or center-aligned (up, then down). In a pseudo-random mode the compare value is tested against a free-running LFSR instead of the count. A capture event latches the running count. The period and compare values are double-buffered, so a change never tears a PWM cycle.

The true and complementary outputs never overlap. Each rising edge is held back by a programmable number of clock cycles after the opposite output has fallen. A kill input overrides both outputs with configured safe levels in the same cycle. The override is held until a new period begins after kill is released.

Top module: `pwm_dbk_top`

## Requirements
- R1: While `en` is low the counter is held at 0 and neither `tc_pulse` nor `cm_pulse` is raised. After reset, with kill low, `pwm_hi` is 0, `pwm_lo` is 1 and `capt_val` is 0.
- R2: Edge-aligned mode is selected by `mode_wdata[1:0]=0`. The count rises by one per clock from 0 to the period. `tc_pulse` is high in the cycle where the count equals the period, and the count returns to 0 on the next clock. The raw duty level is high while the count is below compare.
- R3: One-shot is selected by `mode_wdata[2]=1`. After the first `tc_pulse` the counter stops, and no further `tc_pulse` or `cm_pulse` occurs until `en` is taken low. The raw duty level is 0 while stopped.
- R4: Center-aligned mode is selected by `mode_wdata[1:0]=1`. The count goes up to the period, then down to 0. `tc_pulse` is high in the cycle where the count reaches 0 while falling. The raw duty level is high while the count is below compare.
- R5: Pseudo-random mode is selected by `mode_wdata[1:0]=2`. A 16-bit LFSR starts at 0xACE1 whenever `en` is low. While running it advances once per clock as a right shift, XOR-ing 0xB400 when the bit shifted out is 1. The raw duty level is high while the LFSR value is below compare. The count still runs as in R2 and sets the period.
- R6: `pwm_hi` follows the raw duty level one clock later, but each rise is delayed by a further `dt` clocks, where `dt` is the 8-bit dead time. `pwm_lo` follows the inverse of the raw level in the same way. The two outputs are never high together. With a dead time of 0 they are exact complements.
- R7: Period and compare writes made while the counter runs take effect on the clock after the next `tc_pulse`. Writes made while `en` is low take effect on the next clock. Dead time, mode and kill levels take effect on the next clock.
- R8: A clock edge with `capt_evt` high loads the current count into `capt_val`. The new value is visible in the following cycle.
- R9: While `kill` is high, `pwm_hi` equals kill level bit 0 and `pwm_lo` equals kill level bit 1. This holds in the same cycle, without waiting for a clock edge.
- R10: After `kill` falls, the kill levels stay on the outputs until the clock after the next `tc_pulse`, or until a clock edge with `en` low.
- R11: `cm_pulse` is high in each running cycle in which the compared value (the count, or the LFSR value in pseudo-random mode) equals compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Run enable; low holds the counter idle |
| capt_evt | input | 1 | Capture event |
| kill | input | 1 | Kill override, level sensitive |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period write value |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | 16 | Compare write value |
| dt_we | input | 1 | Dead-time write strobe |
| dt_wdata | input | 8 | Dead time in clocks |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | [1:0] 0 edge, 1 center, 2 pseudo-random; [2] one-shot |
| klvl_we | input | 1 | Kill-level write strobe |
| klvl_wdata | input | 2 | [0] level for pwm_hi, [1] level for pwm_lo |
| pwm_hi | output | 1 | True PWM output |
| pwm_lo | output | 1 | Complementary PWM output |
| tc_pulse | output | 1 | Terminal-count pulse |
| cm_pulse | output | 1 | Compare-match pulse |
| capt_val | output | 16 | Captured count |

## Verification
`tc_pulse` and `cm_pulse` are due in the same cycle as the count state they describe. The PWM pair moves one clock after the raw duty level, plus the dead time on each rise. `capt_val` changes one clock after the event. The kill levels appear in the cycle `kill` is applied. A behavioural model in the bench moves its state on each rising edge from the same inputs. Every output is compared against it 1 ns after each falling edge, after the inputs for that cycle are already applied, so the combinational kill path and the registered paths are both sampled where they settle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_EDGE   = 2'd0,
    MODE_CENTER = 2'd1,
    MODE_PRAND  = 2'd2,
    MODE_RSVD   = 2'd3
  } pwm_mode_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;

  // Galois right-shift step of the maximal-length sequence
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
    logic [LFSR_W-1:0] sh;
    sh = v >> 1;
    return v[0] ? (sh ^ LFSR_MASK) : sh;
  endfunction

  // duty level: high while the tested value is below compare
  function automatic logic duty_level(input logic [LFSR_W-1:0] v,
                                      input logic [LFSR_W-1:0] c);
    return v < c;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tc,
  input  logic                per_we,
  input  logic [CNT_W-1:0]    per_wdata,
  input  logic                cmp_we,
  input  logic [CNT_W-1:0]    cmp_wdata,
  input  logic                dt_we,
  input  logic [DT_W-1:0]     dt_wdata,
  input  logic                mode_we,
  input  logic [2:0]          mode_wdata,
  input  logic                klvl_we,
  input  logic [1:0]          klvl_wdata,
  output logic [CNT_W-1:0]    per_act,
  output logic [CNT_W-1:0]    cmp_act,
  output logic [DT_W-1:0]     dt_q,
  output pwm_pkg::pwm_mode_e  mode_q,
  output logic                oneshot_q,
  output logic [1:0]          klvl_q
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] per_shd, cmp_shd, per_nxt, cmp_nxt;
  logic             load_act;

  // a write in the loading cycle is taken directly
  assign per_nxt  = per_we ? per_wdata : per_shd;
  assign cmp_nxt  = cmp_we ? cmp_wdata : cmp_shd;
  assign load_act = !en || tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_shd   <= '1;
      cmp_shd   <= '0;
      per_act   <= '1;
      cmp_act   <= '0;
      dt_q      <= '0;
      mode_q    <= MODE_EDGE;
      oneshot_q <= 1'b0;
      klvl_q    <= 2'b00;
    end else begin
      per_shd <= per_nxt;
      cmp_shd <= cmp_nxt;
      if (load_act) begin
        per_act <= per_nxt;
        cmp_act <= cmp_nxt;
      end
      if (dt_we)   dt_q <= dt_wdata;
      if (mode_we) begin
        mode_q    <= pwm_mode_e'(mode_wdata[1:0]);
        oneshot_q <= mode_wdata[2];
      end
      if (klvl_we) klvl_q <= klvl_wdata;
    end
  end

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tc) |=> ($stable(per_act) && $stable(cmp_act)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  pwm_pkg::pwm_mode_e mode,
  input  logic               oneshot,
  input  logic [CNT_W-1:0]   per,
  input  logic [CNT_W-1:0]   cmp,
  input  logic               capt_evt,
  output logic               tc,
  output logic               cm,
  output logic               raw,
  output logic [CNT_W-1:0]   capt_val
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lfsr;
  logic             dir_dn;
  logic             done;
  logic             running;
  logic [CNT_W-1:0] src;
  logic             at_top;

  assign running = en && !done;
  assign src     = (mode == MODE_PRAND) ? lfsr : cnt;
  assign at_top  = (cnt == per);
  assign tc      = running && ((mode == MODE_CENTER) ? (dir_dn && cnt == '0) : at_top);
  assign cm      = running && (src == cmp);
  assign raw     = running && duty_level(src, cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      lfsr   <= LFSR_SEED;
      dir_dn <= 1'b0;
      done   <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      lfsr   <= LFSR_SEED;
      dir_dn <= 1'b0;
      done   <= 1'b0;
    end else if (!done) begin
      lfsr <= lfsr_step(lfsr);
      if (mode == MODE_CENTER) begin
        if (!dir_dn) begin
          if (cnt >= per) begin
            dir_dn <= 1'b1;
            cnt    <= (cnt == '0) ? '0 : cnt - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == '0) begin
          if (oneshot) begin
            done <= 1'b1;
          end else begin
            dir_dn <= 1'b0;
            cnt    <= cnt + 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (at_top) begin
        if (oneshot) done <= 1'b1;
        else         cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        capt_val <= '0;
    else if (capt_evt) capt_val <= cnt;
  end

  p_edge_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && mode != MODE_CENTER && !oneshot) |=> (cnt == '0));
  p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && oneshot) |=> !tc);
  p_center_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MODE_CENTER && !dir_dn && at_top && per != '0) |=> (dir_dn || cnt == '0));
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capt_evt |=> (capt_val == $past(cnt)));
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw,
  input  logic [DT_W-1:0] dt,
  output logic            hi,
  output logic            lo
);
  logic            raw_q;
  logic [DT_W-1:0] dcnt;
  logic            settled;

  assign settled = (dcnt == '0);
  assign hi      = raw_q && settled;
  assign lo      = !raw_q && settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      dcnt  <= '0;
    end else begin
      raw_q <= raw;
      if (raw != raw_q)  dcnt <= dt;
      else if (!settled) dcnt <= dcnt - 1'b1;
    end
  end

  p_hi_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi) |-> $past(raw));
  p_hi_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw && $past(raw)) |=> !hi);
  p_lo_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !$past(raw)) |=> !lo);
endmodule

// File: rtl/pwm_dbk_top.sv
module pwm_dbk_top #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             capt_evt,
  input  logic             kill,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             dt_we,
  input  logic [DT_W-1:0]  dt_wdata,
  input  logic             mode_we,
  input  logic [2:0]       mode_wdata,
  input  logic             klvl_we,
  input  logic [1:0]       klvl_wdata,
  output logic             pwm_hi,
  output logic             pwm_lo,
  output logic             tc_pulse,
  output logic             cm_pulse,
  output logic [CNT_W-1:0] capt_val
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] per_act, cmp_act;
  logic [DT_W-1:0]  dt_q;
  pwm_mode_e        mode_q;
  logic             oneshot_q;
  logic [1:0]       klvl_q;
  logic             tc_w, cm_w, raw_w;
  logic             hi_db, lo_db;
  logic             kill_hold, kill_act;

  pwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(en), .tc(tc_w),
    .per_we(per_we), .per_wdata(per_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .dt_we(dt_we), .dt_wdata(dt_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .klvl_we(klvl_we), .klvl_wdata(klvl_wdata),
    .per_act(per_act), .cmp_act(cmp_act), .dt_q(dt_q),
    .mode_q(mode_q), .oneshot_q(oneshot_q), .klvl_q(klvl_q)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode_q), .oneshot(oneshot_q),
    .per(per_act), .cmp(cmp_act), .capt_evt(capt_evt),
    .tc(tc_w), .cm(cm_w), .raw(raw_w), .capt_val(capt_val)
  );

  pwm_deadband #(.DT_W(DT_W)) u_db (
    .clk(clk), .rst_n(rst_n), .raw(raw_w), .dt(dt_q), .hi(hi_db), .lo(lo_db)
  );

  // kill latches until a period boundary or idle once released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            kill_hold <= 1'b0;
    else if (kill)         kill_hold <= 1'b1;
    else if (tc_w || !en)  kill_hold <= 1'b0;
  end

  assign kill_act = kill || kill_hold;
  assign pwm_hi   = kill_act ? klvl_q[0] : hi_db;
  assign pwm_lo   = kill_act ? klvl_q[1] : lo_db;
  assign tc_pulse = tc_w;
  assign cm_pulse = cm_w;

  p_kill_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (pwm_hi == klvl_q[0] && pwm_lo == klvl_q[1]));
  p_kill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && en) |=> (pwm_hi == klvl_q[0] && pwm_lo == klvl_q[1]));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!tc_pulse && !cm_pulse));
endmodule

// File: tb/sim_pwm_dbk_top.sv
`timescale 1ns/1ps
module sim_pwm_dbk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, capt_evt = 1'b0, kill = 1'b0;
  logic        per_we = 1'b0, cmp_we = 1'b0, dt_we = 1'b0, mode_we = 1'b0, klvl_we = 1'b0;
  logic [15:0] per_wdata = '0, cmp_wdata = '0;
  logic [7:0]  dt_wdata = '0;
  logic [2:0]  mode_wdata = '0;
  logic [1:0]  klvl_wdata = '0;
  logic        pwm_hi, pwm_lo, tc_pulse, cm_pulse;
  logic [15:0] capt_val;

  int checks = 0, failures = 0;
  string ptag = "R1";
  int tc_seen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwm_dbk_top u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .capt_evt(capt_evt), .kill(kill),
    .per_we(per_we), .per_wdata(per_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .dt_we(dt_we), .dt_wdata(dt_wdata), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .klvl_we(klvl_we), .klvl_wdata(klvl_wdata),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .tc_pulse(tc_pulse), .cm_pulse(cm_pulse),
    .capt_val(capt_val)
  );

  // behavioural reference state
  int m_per_s = 65535, m_cmp_s = 0, m_per = 65535, m_cmp = 0;
  int m_dt = 0, m_mode = 0, m_os = 0, m_klvl = 0;
  int m_cnt = 0, m_dn = 0, m_lfsr = 'hACE1, m_done = 0, m_cap = 0;
  int m_rawprev = 0, m_since = 1000, m_dtl = 0, m_hold = 0;

  function automatic int m_run();  return (en && m_done == 0) ? 1 : 0; endfunction
  function automatic int m_src();  return (m_mode == 2) ? m_lfsr : m_cnt; endfunction
  function automatic int m_raw();  return (m_run() != 0 && m_src() < m_cmp) ? 1 : 0; endfunction
  function automatic int m_cm();   return (m_run() != 0 && m_src() == m_cmp) ? 1 : 0; endfunction
  function automatic int m_tc();
    if (m_run() == 0) return 0;
    if (m_mode == 1) return (m_dn != 0 && m_cnt == 0) ? 1 : 0;
    return (m_cnt == m_per) ? 1 : 0;
  endfunction
  function automatic int m_killed(); return (kill || m_hold != 0) ? 1 : 0; endfunction
  function automatic int m_hi();
    if (m_killed() != 0) return m_klvl % 2;
    return (m_rawprev != 0 && m_since >= m_dtl) ? 1 : 0;
  endfunction
  function automatic int m_lo();
    if (m_killed() != 0) return m_klvl / 2;
    return (m_rawprev == 0 && m_since >= m_dtl) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_per_s = 65535; m_cmp_s = 0; m_per = 65535; m_cmp = 0;
      m_dt = 0; m_mode = 0; m_os = 0; m_klvl = 0;
      m_cnt = 0; m_dn = 0; m_lfsr = 'hACE1; m_done = 0; m_cap = 0;
      m_rawprev = 0; m_since = 1000; m_dtl = 0; m_hold = 0;
    end else begin
      int r, t, np, nc;
      r = m_raw(); t = m_tc();
      if (kill) m_hold = 1; else if (t != 0 || !en) m_hold = 0;
      if (capt_evt) m_cap = m_cnt;
      if (r != m_rawprev) begin m_since = 0; m_dtl = m_dt; end
      else if (m_since < 1000) m_since++;
      m_rawprev = r;
      if (!en) begin
        m_cnt = 0; m_dn = 0; m_lfsr = 'hACE1; m_done = 0;
      end else if (m_done == 0) begin
        m_lfsr = (m_lfsr % 2 != 0) ? ((m_lfsr / 2) ^ 'hB400) : (m_lfsr / 2);
        if (m_mode == 1) begin
          if (m_dn == 0) begin
            if (m_cnt >= m_per) begin m_dn = 1; if (m_cnt > 0) m_cnt--; end
            else m_cnt++;
          end else if (m_cnt == 0) begin
            if (m_os != 0) m_done = 1; else begin m_dn = 0; m_cnt = 1; end
          end else m_cnt--;
        end else if (m_cnt == m_per) begin
          if (m_os != 0) m_done = 1; else m_cnt = 0;
        end else m_cnt++;
      end
      np = per_we ? int'(per_wdata) : m_per_s;
      nc = cmp_we ? int'(cmp_wdata) : m_cmp_s;
      m_per_s = np; m_cmp_s = nc;
      if (!en || t != 0) begin m_per = np; m_cmp = nc; end
      if (dt_we) m_dt = int'(dt_wdata);
      if (mode_we) begin m_mode = int'(mode_wdata[1:0]); m_os = int'(mode_wdata[2]); end
      if (klvl_we) m_klvl = int'(klvl_wdata);
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle after inputs settle
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk({ptag, " R6"}, "pwm_hi", int'(pwm_hi), m_hi());
      chk({ptag, " R6"}, "pwm_lo", int'(pwm_lo), m_lo());
      chk({ptag, " R2"}, "tc_pulse", int'(tc_pulse), m_tc());
      chk({ptag, " R11"}, "cm_pulse", int'(cm_pulse), m_cm());
      chk({ptag, " R8"}, "capt_val", int'(capt_val), m_cap);
      if (tc_pulse) tc_seen++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int per, input int cmp, input int dt, input int mode);
    @(negedge clk);
    per_we = 1; per_wdata = 16'(per); cmp_we = 1; cmp_wdata = 16'(cmp);
    dt_we = 1; dt_wdata = 8'(dt); mode_we = 1; mode_wdata = 3'(mode);
    @(negedge clk);
    per_we = 0; cmp_we = 0; dt_we = 0; mode_we = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    #1.5;
    chk("R1", "reset pwm_hi", int'(pwm_hi), 0);
    chk("R1", "reset pwm_lo", int'(pwm_lo), 1);
    chk("R1", "reset tc", int'(tc_pulse), 0);
    chk("R1", "reset capt", int'(capt_val), 0);
    cyc(2);

    ptag = "R2";
    wr(9, 4, 0, 0);
    @(negedge clk); en = 1;
    cyc(12);
    @(negedge clk); capt_evt = 1; @(negedge clk); capt_evt = 0;
    cyc(7);
    @(negedge clk); capt_evt = 1; cyc(3); capt_evt = 0;
    cyc(10);

    ptag = "R6";
    @(negedge clk); dt_we = 1; dt_wdata = 2; @(negedge clk); dt_we = 0;
    cyc(30);
    @(negedge clk); dt_we = 1; dt_wdata = 5; @(negedge clk); dt_we = 0;
    cyc(25);

    ptag = "R7";
    @(negedge clk); per_we = 1; per_wdata = 12; cmp_we = 1; cmp_wdata = 7;
    dt_we = 1; dt_wdata = 1;
    @(negedge clk); per_we = 0; cmp_we = 0; dt_we = 0;
    cyc(40);

    ptag = "R9";
    @(negedge clk); klvl_we = 1; klvl_wdata = 2'b01; @(negedge clk); klvl_we = 0;
    cyc(3);
    @(negedge clk); kill = 1; #1.5;
    chk("R9", "kill pwm_hi", int'(pwm_hi), 1);
    chk("R9", "kill pwm_lo", int'(pwm_lo), 0);
    cyc(6);
    ptag = "R10";
    @(negedge clk); kill = 0;
    cyc(30);

    ptag = "R4";
    @(negedge clk); en = 0;
    wr(6, 3, 1, 1);
    @(negedge clk); en = 1;
    cyc(45);

    ptag = "R5";
    @(negedge clk); en = 0;
    wr(20, 'h8000, 0, 2);
    @(negedge clk); en = 1;
    cyc(70);

    ptag = "R3";
    @(negedge clk); en = 0;
    wr(5, 2, 0, 4);
    tc_seen = 0;
    @(negedge clk); en = 1;
    cyc(25);
    chk("R3", "one-shot tc count", tc_seen, 1);
    chk("R3", "stopped pwm_hi", int'(pwm_hi), 0);
    @(negedge clk); en = 0;
    cyc(4);
    chk("R1", "idle tc", int'(tc_pulse), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule